// File: doc/BRIEF.md
# PHY Reset and Receive-PLL Lock Sequencer

This block brings a serial-link PHY out of reset after its PLL clock has been switched on. It does so through a command port to a separate control-register handshake master. A single start request runs the whole script. First the block waits for the PLL clock to settle. It then selects the PHY clock-reset register and writes a value with the reset bit set. After that it repeatedly reads the lane-0 output-status register until the receive PLL reports that it has locked. A final settling delay follows before completion is reported.

The enclosing enable logic sees one `done_o` pulse per run. `fail_o` is valid in that same cycle. A run fails in two ways: the lock bit never appears within the retry budget, or any command reports an error. A command error ends the run at once and no further command is issued. All delays are given in microseconds and converted to clock cycles through a cycles-per-microsecond parameter.

Top module: `phy_boot_seq`

## Requirements
- R1: After reset, `done_o` and `cmd_valid_o` are low and no command is issued until `start_i` is seen.
- R2: After an accepted start, the first command is issued no earlier than `SETTLE_US*CYC_PER_US` cycles later.
- R3: The reset step has two commands. The first is an address capture (`cmd_type_o` = 0) of 0x7F3F. The second is a write (`cmd_type_o` = 1) of 0x0001, whose bit 0 is the reset bit.
- R4: Only one command is outstanding at a time. `cmd_valid_o` is a one-cycle pulse. It is raised only when `cmd_busy_i` was low in the previous cycle, and never before the previous command's `cmd_done_i`.
- R5: Each lock poll starts at least `POLL_US*CYC_PER_US` cycles after the previous command completed. A poll is an address capture of 0x2003 followed by a read (`cmd_type_o` = 2, data 0x0000). Only bit 1 of `cmd_rdata_i` decides lock; all other bits are ignored.
- R6: When a read returns bit 1 set, `done_o` pulses with `fail_o` = 0. The pulse comes no earlier than `POST_US*CYC_PER_US` cycles after that read completed.
- R7: At most `POLL_MAX` (default 10) reads are made. If none shows the lock bit, `done_o` pulses with `fail_o` = 1. A lock seen on the last allowed read still counts as success.
- R8: A `cmd_done_i` that comes with `cmd_err_i` high causes `done_o` with `fail_o` = 1 in the next cycle, and no further command is issued.
- R9: `done_o` is high for exactly one cycle per run.
- R10: `start_i` is ignored while a run is in progress. A start present in the cycle in which `done_o` is high is accepted as a new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to run the bring-up script |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | Outcome, valid with `done_o`: 1 = timeout or command error |
| cmd_valid_o | output | 1 | One-cycle command issue strobe |
| cmd_type_o | output | 2 | 0 = address capture, 1 = write, 2 = read |
| cmd_data_o | output | DW | Address or write value for the command |
| cmd_busy_i | input | 1 | Handshake master cannot take a command |
| cmd_done_i | input | 1 | Outstanding command finished |
| cmd_err_i | input | 1 | Outstanding command failed, valid with `cmd_done_i` |
| cmd_rdata_i | input | DW | Read result, valid with `cmd_done_i` |

## Verification
Completion of one run and acceptance of the next can fall into the same cycle. The bench raises `start_i` in the very cycle it sees `done_o` high. It then expects a complete second script, with fresh settle timing, and exactly one further `done_o`. The opposite case is also covered: start pulses placed inside the settle wait and inside a poll must produce neither extra commands nor a second completion. A command error is also placed on a mid-loop read, so that failure and a lock decision compete for the same completion cycle.

// File: rtl/phy_boot_pkg.sv
package phy_boot_pkg;

   typedef enum logic [1:0] {
      PB_CMD_ADDR  = 2'd0,
      PB_CMD_WRITE = 2'd1,
      PB_CMD_READ  = 2'd2
   } pb_cmd_e;

   typedef enum logic [2:0] {
      PB_IDLE,
      PB_SETTLE,
      PB_RST_ADDR,
      PB_RST_WR,
      PB_POLL_DLY,
      PB_POLL_ADDR,
      PB_POLL_RD,
      PB_POST
   } pb_state_e;

endpackage

// File: rtl/phy_boot_timer.sv
module phy_boot_timer #(
   parameter int CYC_PER_US = 100,
   parameter int UW         = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [UW-1:0] us_i,
   output logic          fire_o
);

   logic          run_q;
   logic [UW-1:0] us_q;
   logic          tick;

   generate
      if (CYC_PER_US == 1) begin : g_direct
         assign tick = run_q;
      end else begin : g_prescale
         localparam int PW = $clog2(CYC_PER_US);
         logic [PW-1:0] pre_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pre_q <= '0;
            end else if (load_i || tick) begin
               pre_q <= '0;
            end else if (run_q) begin
               pre_q <= pre_q + 1'b1;
            end
         end
         assign tick = run_q && (pre_q == PW'(CYC_PER_US - 1));
      end
   endgenerate

   assign fire_o = tick && (us_q == UW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         us_q  <= '0;
      end else if (load_i) begin
         run_q <= 1'b1;
         us_q  <= us_i;
      end else if (fire_o) begin
         run_q <= 1'b0;
      end else if (tick) begin
         us_q <= us_q - 1'b1;
      end
   end

   // R2
   one_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire_o |=> !fire_o);

endmodule

// File: rtl/phy_boot_tries.sv
module phy_boot_tries #(
   parameter int MAX = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic inc_i,
   output logic last_o
);

   localparam int AW = $clog2(MAX + 1);

   logic [AW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (inc_i) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign last_o = (cnt_q == AW'(MAX - 1));

   // R7
   try_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inc_i |-> (cnt_q < AW'(MAX - 1)));

endmodule

// File: rtl/phy_boot_seq.sv
module phy_boot_seq
   import phy_boot_pkg::*;
#(
   parameter int            CYC_PER_US    = 100,
   parameter int            SETTLE_US     = 100,
   parameter int            POLL_US       = 100,
   parameter int            POST_US       = 1000,
   parameter int            POLL_MAX      = 10,
   parameter int            DW            = 16,
   parameter int            LOCK_BIT      = 1,
   parameter logic [DW-1:0] RST_REG_ADDR  = 'h7F3F,
   parameter logic [DW-1:0] RST_REG_VAL   = 'h0001,
   parameter logic [DW-1:0] LOCK_REG_ADDR = 'h2003
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   output logic          done_o,
   output logic          fail_o,
   output logic          cmd_valid_o,
   output logic [1:0]    cmd_type_o,
   output logic [DW-1:0] cmd_data_o,
   input  logic          cmd_busy_i,
   input  logic          cmd_done_i,
   input  logic          cmd_err_i,
   input  logic [DW-1:0] cmd_rdata_i
);

   localparam int MAX_A  = (SETTLE_US > POLL_US) ? SETTLE_US : POLL_US;
   localparam int MAX_US = (MAX_A > POST_US) ? MAX_A : POST_US;
   localparam int UW     = $clog2(MAX_US + 1);
   localparam logic [DW-1:0] LOCK_MASK = DW'(1) << LOCK_BIT;

   generate
      if (CYC_PER_US < 1) begin : g_bad_cyc
         $error("CYC_PER_US must be at least 1");
      end
      if (SETTLE_US < 1 || POLL_US < 1 || POST_US < 1) begin : g_bad_us
         $error("every delay must be at least 1 us");
      end
      if (POLL_MAX < 1) begin : g_bad_max
         $error("POLL_MAX must be at least 1");
      end
      if (LOCK_BIT >= DW) begin : g_bad_bit
         $error("LOCK_BIT outside the data width");
      end
   endgenerate

   pb_state_e     state_q;
   logic          pend_q;
   pb_cmd_e       type_q;
   logic [DW-1:0] data_q;
   logic          tmr_load_q;
   logic [UW-1:0] tmr_us_q;
   logic          tmr_fire;
   logic          try_clr_q;
   logic          try_inc_q;
   logic          try_last;
   pb_cmd_e       cur_type;
   logic [DW-1:0] cur_data;
   logic          is_cmd;
   logic          lock_hit;

   phy_boot_timer #(
      .CYC_PER_US (CYC_PER_US),
      .UW         (UW)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (tmr_load_q),
      .us_i   (tmr_us_q),
      .fire_o (tmr_fire)
   );

   phy_boot_tries #(
      .MAX (POLL_MAX)
   ) u_tries (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (try_clr_q),
      .inc_i  (try_inc_q),
      .last_o (try_last)
   );

   always_comb begin
      cur_type = PB_CMD_ADDR;
      cur_data = '0;
      is_cmd   = 1'b1;
      case (state_q)
         PB_RST_ADDR:  cur_data = RST_REG_ADDR;
         PB_RST_WR: begin
            cur_type = PB_CMD_WRITE;
            cur_data = RST_REG_VAL;
         end
         PB_POLL_ADDR: cur_data = LOCK_REG_ADDR;
         PB_POLL_RD:   cur_type = PB_CMD_READ;
         default:      is_cmd   = 1'b0;
      endcase
   end

   assign lock_hit = |(cmd_rdata_i & LOCK_MASK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= PB_IDLE;
         pend_q      <= 1'b0;
         cmd_valid_o <= 1'b0;
         type_q      <= PB_CMD_ADDR;
         data_q      <= '0;
         done_o      <= 1'b0;
         fail_o      <= 1'b0;
         tmr_load_q  <= 1'b0;
         tmr_us_q    <= '0;
         try_clr_q   <= 1'b0;
         try_inc_q   <= 1'b0;
      end else begin
         cmd_valid_o <= 1'b0;
         done_o      <= 1'b0;
         tmr_load_q  <= 1'b0;
         try_clr_q   <= 1'b0;
         try_inc_q   <= 1'b0;
         if (state_q == PB_IDLE) begin
            if (start_i) begin
               state_q    <= PB_SETTLE;
               tmr_load_q <= 1'b1;
               tmr_us_q   <= UW'(SETTLE_US);
               try_clr_q  <= 1'b1;
            end
         end else if (state_q == PB_SETTLE || state_q == PB_POLL_DLY) begin
            if (tmr_fire) begin
               state_q <= (state_q == PB_SETTLE) ? PB_RST_ADDR : PB_POLL_ADDR;
            end
         end else if (state_q == PB_POST) begin
            if (tmr_fire) begin
               state_q <= PB_IDLE;
               done_o  <= 1'b1;
               fail_o  <= 1'b0;
            end
         end else if (is_cmd) begin
            if (!pend_q) begin
               if (!cmd_busy_i) begin
                  cmd_valid_o <= 1'b1;
                  pend_q      <= 1'b1;
                  type_q      <= cur_type;
                  data_q      <= cur_data;
               end
            end else if (cmd_done_i) begin
               pend_q <= 1'b0;
               if (cmd_err_i) begin
                  state_q <= PB_IDLE;
                  done_o  <= 1'b1;
                  fail_o  <= 1'b1;
               end else begin
                  case (state_q)
                     PB_RST_ADDR:  state_q <= PB_RST_WR;
                     PB_POLL_ADDR: state_q <= PB_POLL_RD;
                     PB_RST_WR: begin
                        state_q    <= PB_POLL_DLY;
                        tmr_load_q <= 1'b1;
                        tmr_us_q   <= UW'(POLL_US);
                     end
                     default: begin
                        if (lock_hit) begin
                           state_q    <= PB_POST;
                           tmr_load_q <= 1'b1;
                           tmr_us_q   <= UW'(POST_US);
                        end else if (try_last) begin
                           state_q <= PB_IDLE;
                           done_o  <= 1'b1;
                           fail_o  <= 1'b1;
                        end else begin
                           state_q    <= PB_POLL_DLY;
                           tmr_load_q <= 1'b1;
                           tmr_us_q   <= UW'(POLL_US);
                           try_inc_q  <= 1'b1;
                        end
                     end
                  endcase
               end
            end
         end
      end
   end

   assign cmd_type_o = type_q;
   assign cmd_data_o = data_q;

   // R4
   cmd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid_o |=> !cmd_valid_o);

   // R4
   cmd_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid_o |-> !$past(cmd_busy_i));

   // R3
   rst_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid_o && cmd_type_o == PB_CMD_WRITE) |-> cmd_data_o[0]);

   // R8
   hs_err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && cmd_done_i && cmd_err_i) |=> (done_o && fail_o));

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

endmodule

// File: tb/phy_boot_seq_tb.sv
`timescale 1ns/1ps
module phy_boot_seq_tb;
   import phy_boot_pkg::*;

   localparam int CYC = 2, SETTLE = 100, POLL = 100, POST = 1000, TRIES = 10;

   logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic        done_o, fail_o, cmd_valid_o;
   logic [1:0]  cmd_type_o;
   logic [15:0] cmd_data_o;
   logic        busy = 1'b0, cdone = 1'b0, cerr = 1'b0;
   logic [15:0] rdata = '0;

   typedef struct {logic [1:0] t; logic [15:0] d;} exp_t;
   exp_t exp_q[$];

   int checks = 0, errors = 0, cyc = 0;
   int lock_at = 0, err_idx = -1, cmd_idx = 0, read_no = 0, cmd_seen = 0;
   int t_start = 0, t_last_done = 0;
   logic [15:0] miss_pat = '0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   phy_boot_seq #(
      .CYC_PER_US (CYC), .SETTLE_US (SETTLE), .POLL_US (POLL),
      .POST_US (POST), .POLL_MAX (TRIES)
   ) u_dut (
      .clk (clk), .rst_n (rst_n), .start_i (start), .done_o (done_o),
      .fail_o (fail_o), .cmd_valid_o (cmd_valid_o), .cmd_type_o (cmd_type_o),
      .cmd_data_o (cmd_data_o), .cmd_busy_i (busy), .cmd_done_i (cdone),
      .cmd_err_i (cerr), .cmd_rdata_i (rdata)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // handshake master model and scoreboard monitor
   initial begin
      int cnt = 0;
      bit vdur = 0;
      logic [1:0] lt = 2'd0;
      forever begin
         @(negedge clk);
         if (cnt > 0) begin
            if (cmd_valid_o) vdur = 1;
            cnt--;
            if (cnt == 0) begin
               busy  = 1'b0;
               cdone = 1'b1;
               cerr  = (cmd_idx == err_idx);
               rdata = (lt == 2'd2) ?
                       ((lock_at != 0 && read_no >= lock_at) ? 16'h0002 : miss_pat) : 16'h0;
               chk(!vdur, "R4", "command issued while outstanding", int'(vdur), 0);
               cmd_idx++;
               t_last_done = cyc;
            end
         end else begin
            cdone = 1'b0;
            cerr  = 1'b0;
            if (cmd_valid_o) begin
               exp_t e;
               cmd_seen++;
               if (exp_q.size() == 0) begin
                  chk(0, "R8", "unexpected command type", int'(cmd_type_o), -1);
               end else begin
                  e = exp_q.pop_front();
                  chk(cmd_type_o == e.t, "R3", "command type", int'(cmd_type_o), int'(e.t));
                  chk(cmd_data_o == e.d, "R3", "command data", int'(cmd_data_o), int'(e.d));
               end
               if (cmd_type_o == 2'd0 && cmd_data_o == 16'h7F3F)
                  chk(cyc - t_start >= SETTLE*CYC, "R2", "settle cycles",
                      cyc - t_start, SETTLE*CYC);
               if (cmd_type_o == 2'd0 && cmd_data_o == 16'h2003)
                  chk(cyc - t_last_done >= POLL*CYC, "R5", "poll wait cycles",
                      cyc - t_last_done, POLL*CYC);
               if (cmd_type_o == 2'd2) read_no++;
               lt   = cmd_type_o;
               busy = 1'b1;
               cnt  = 3;
               vdur = 0;
            end
         end
      end
   end

   // driver: pushes the expected command script
   task automatic plan_run(input int lock, input int erri, input logic [15:0] miss);
      int n;
      int att;
      lock_at = lock; err_idx = erri; miss_pat = miss; cmd_idx = 0; read_no = 0;
      exp_q.push_back('{2'd0, 16'h7F3F});
      if (erri == 0) return;
      exp_q.push_back('{2'd1, 16'h0001});
      if (erri == 1) return;
      n   = 2;
      att = (lock == 0) ? TRIES : lock;
      for (int a = 0; a < att; a++) begin
         exp_q.push_back('{2'd0, 16'h2003});
         if (n == erri) return;
         n++;
         exp_q.push_back('{2'd2, 16'h0000});
         if (n == erri) return;
         n++;
      end
   endtask

   task automatic kick();
      @(negedge clk);
      start = 1'b1;
      t_start = cyc;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done(output bit f);
      int k = 0;
      while (!done_o && k < 40000) begin
         @(negedge clk);
         k++;
      end
      chk(done_o, "R9", "done seen", int'(done_o), 1);
      f = fail_o;
   endtask

   task automatic after_done(input bit f, input bit ef, input string req);
      chk(f == ef, req, "fail flag", int'(f), int'(ef));
      if (!ef) chk(cyc - t_last_done >= POST*CYC, "R6", "post delay cycles",
                   cyc - t_last_done, POST*CYC);
      @(negedge clk);
      chk(!done_o, "R9", "done one cycle", int'(done_o), 0);
      chk(exp_q.size() == 0, req, "commands left", exp_q.size(), 0);
   endtask

   always @(posedge clk) begin
      if (cyc > 150000) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      bit f;
      int seen0;
      repeat (5) @(negedge clk);
      chk(!done_o, "R1", "done in reset", int'(done_o), 0);
      chk(!cmd_valid_o, "R1", "valid in reset", int'(cmd_valid_o), 0);
      rst_n = 1'b1;
      repeat (20) @(negedge clk);
      chk(cmd_seen == 0 && !done_o, "R1", "idle without start", cmd_seen, 0);

      // R6: lock on the first poll
      plan_run(1, -1, 16'h0000); kick(); wait_done(f); after_done(f, 0, "R6");
      // R5: other status bits set, lock on fourth poll
      plan_run(4, -1, 16'hFFFD); kick(); wait_done(f); after_done(f, 0, "R5");
      // R7: never locks
      seen0 = cmd_seen;
      plan_run(0, -1, 16'hFFFD); kick(); wait_done(f); after_done(f, 1, "R7");
      chk(cmd_seen - seen0 == 2 + 2*TRIES, "R7", "command count", cmd_seen - seen0, 2 + 2*TRIES);
      // R7: lock on the last allowed read
      plan_run(TRIES, -1, 16'h0000); kick(); wait_done(f); after_done(f, 0, "R7");
      // R8: error on the reset write
      plan_run(1, 1, 16'h0000); kick(); wait_done(f); after_done(f, 1, "R8");
      seen0 = cmd_seen;
      repeat (600) @(negedge clk);
      chk(cmd_seen == seen0, "R8", "commands after error", cmd_seen - seen0, 0);
      // R8: error on the second read
      plan_run(3, 5, 16'h0000); kick(); wait_done(f); after_done(f, 1, "R8");

      // R10: start pulses during a run are ignored
      seen0 = cmd_seen;
      plan_run(1, -1, 16'h0000); kick();
      repeat (60) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
      while (read_no == 0) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
      wait_done(f); after_done(f, 0, "R10");
      begin
         int extra = 0;
         for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (done_o) extra++;
         end
         chk(extra == 0 && cmd_seen - seen0 == 4, "R10", "commands of ignored starts",
             cmd_seen - seen0, 4);
      end

      // R10: start in the same cycle as done
      plan_run(1, -1, 16'h0000); kick();
      wait_done(f);
      chk(!f, "R10", "first run fail flag", int'(f), 0);
      start = 1'b1;
      t_start = cyc;
      plan_run(2, -1, 16'h0000);
      @(negedge clk);
      start = 1'b0;
      chk(!done_o, "R9", "done one cycle", int'(done_o), 0);
      wait_done(f); after_done(f, 0, "R10");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule